// File: doc/BRIEF.md
# Packet Receive FIFO with Host Status Flags

This block buffers the bytes of incoming radio frames between the demodulator and a host controller. Each frame enters as a run of byte writes. The first byte is the frame length. Frames are stacked back to back in one shared store of `DEPTH` bytes. Three level outputs tell the host what is happening:

- `frame_act`: a frame is being received.
- `not_empty`: there is at least one unread byte.
- `ready`: enough data is waiting, or a whole frame has arrived.

The host pulls bytes with a read strobe. The oldest byte is always visible on `rd_data`.

Address recognition is resolved while a frame arrives. When recognition is enabled, `ready` is held back for the incoming frame until it passes. A frame that fails is removed: the write position returns to where that frame began, and older frames stay untouched. A write that finds the store full sets a sticky overflow. Overflow is shown as `not_empty` low together with `ready` high. While it lasts, stored bytes can still be read, but new data is refused until a flush. A frame cut short by overflow stays marked active across the first flush, so a second flush is needed to clear `frame_act`.

Top module: `rx_pkt_fifo`

## Requirements
- R1: The store holds up to 128 bytes across any number of complete or partial frames. Writing exactly 128 bytes causes no overflow.
- R2: `not_empty` is 1 exactly when at least one unread byte is stored and no overflow is flagged. It rises on the clock after the frame's first (length) byte is written.
- R3: With no gating and no end-of-frame pending, `ready` is 1 exactly when the unread byte count is strictly greater than `thr`.
- R4: While `addr_en` is 1 and the active frame has not yet passed recognition (an `addr_pass` pulse), the threshold term of `ready` is held low. It is released on the clock after `addr_pass`.
- R5: A write with `eof` set raises `ready` on the next clock, whatever the threshold. That end-of-frame term clears after the next accepted read.
- R6: `frame_act` rises on the clock after `sof`. It falls on the clock after the accepted write that carries `eof`.
- R7: An `addr_fail` pulse with `addr_en` = 1 during an active frame has these effects:
  - `frame_act` drops on the next clock.
  - Every byte of that frame is discarded, including any write in the same cycle.
  - Bytes of earlier frames remain and read out unchanged.
- R8: A write during an active frame while 128 bytes are stored sets overflow. Overflow drives `not_empty` = 0 and `ready` = 1. Stored bytes stay readable in order.
- R9: During overflow, writes and `sof` are ignored. The first flush clears the stored data and the overflow but leaves `frame_act` at 1. A second flush clears `frame_act`. After that, new frames are accepted again.
- R10: A flush without overflow empties the store in one cycle. It also ends any active frame and any pending end-of-frame `ready`.
- R11: A read and an accepted write in the same cycle leave the byte count unchanged. A read while empty is ignored.
- R12: `rd_data` always shows the oldest unread byte. Bytes leave in the order they were written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sof | input | 1 | Pulse: start-of-frame delimiter fully received |
| wr_en | input | 1 | Pulse: a received byte is on `wr_data` |
| wr_data | input | DATA_W | Received byte |
| eof | input | 1 | Set together with `wr_en` on the frame's last byte |
| addr_en | input | 1 | Address recognition enabled (level) |
| addr_pass | input | 1 | Pulse: active frame passed recognition |
| addr_fail | input | 1 | Pulse: active frame failed recognition |
| rd_en | input | 1 | Host read strobe; advances past `rd_data` |
| rd_data | output | DATA_W | Oldest unread byte (valid while bytes are stored) |
| flush | input | 1 | Pulse: clear stored data |
| thr | input | log2(DEPTH) | `ready` threshold on the unread byte count |
| frame_act | output | 1 | Frame reception in progress |
| not_empty | output | 1 | Unread data present and no overflow |
| ready | output | 1 | Threshold exceeded, frame complete, or overflow |

## Verification
The properties assume the following about the inputs:
- `sof` and `wr_en` never share a cycle.
- A frame gets at most one recognition verdict, and that verdict comes before its `eof`.
- The host never reads bytes of a frame whose recognition is still pending, because a rollback would then cut below the read position.

The stimulus, directed and random, follows these rules. Its model enables a read only while more bytes are stored than the current frame has written. It places `addr_pass` in the middle of a frame. It issues `sof` only in cycles with no write.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

  // Frame-level state shared between the control and flag logic.
  typedef struct packed {
    logic frame_act;  // a frame is being received
    logic passed;     // active frame passed address recognition
    logic done;       // end-of-frame seen, no byte read since
    logic ovf;        // sticky overflow
  } rxf_stat_t;

endpackage

// File: rtl/rxf_store.sv
// Byte store with extended pointers. DEPTH must be a power of two so the
// pointer difference gives the byte count directly.
module rxf_store #(
  parameter int DEPTH  = 128,
  parameter int DATA_W = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              wr_acc,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic              rollback,
  input  logic [CNT_W-1:0]  roll_ptr,
  output logic [CNT_W-1:0]  wptr,
  output logic [CNT_W-1:0]  count,
  output logic              full,
  output logic              rd_ok,
  output logic [DATA_W-1:0] rd_data
);

  localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [CNT_W-1:0]  wptr_q, wptr_d;
  logic [CNT_W-1:0]  rptr_q, rptr_d;

  assign count   = wptr_q - rptr_q;
  assign full    = (count == FULL_CNT);
  assign rd_ok   = rd_en && (count != '0) && !flush;
  assign wptr    = wptr_q;
  assign rd_data = mem[rptr_q[PTR_W-1:0]];

  always_comb begin
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    if (flush) begin
      wptr_d = '0;
      rptr_d = '0;
    end else begin
      if (rollback)
        wptr_d = roll_ptr;
      else if (wr_acc)
        wptr_d = wptr_q + ONE;
      if (rd_ok)
        rptr_d = rptr_q + ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
    end
  end

  // Data array: no reset, written only on an accepted byte.
  always_ff @(posedge clk) begin
    if (wr_acc)
      mem[wptr_q[PTR_W-1:0]] <= wr_data;
  end

endmodule

// File: rtl/rxf_frame_ctl.sv
// Frame tracking: start/end, recognition verdict, rollback, overflow.
module rxf_frame_ctl
  import rxf_pkg::*;
#(
  parameter int DEPTH  = 128,
  localparam int CNT_W = $clog2(DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             sof,
  input  logic             eof,
  input  logic             wr_en,
  input  logic             addr_en,
  input  logic             addr_pass,
  input  logic             addr_fail,
  input  logic             full,
  input  logic             rd_ok,
  input  logic [CNT_W-1:0] wptr,
  output logic             wr_acc,
  output logic             rollback,
  output logic [CNT_W-1:0] roll_ptr,
  output rxf_stat_t        stat
);

  rxf_stat_t        stat_q, stat_d;
  logic [CNT_W-1:0] sof_ptr_q, sof_ptr_d;
  logic             pass_ok, fail_ok, wr_try, ovf_set;

  assign pass_ok  = stat_q.frame_act && addr_en && addr_pass && !flush;
  assign fail_ok  = stat_q.frame_act && addr_en && addr_fail && !flush;
  assign wr_try   = wr_en && stat_q.frame_act && !stat_q.ovf && !fail_ok && !flush;
  assign wr_acc   = wr_try && !full;
  assign ovf_set  = wr_try && full;
  assign rollback = fail_ok;
  assign roll_ptr = sof_ptr_q;
  assign stat     = stat_q;

  always_comb begin
    stat_d    = stat_q;
    sof_ptr_d = sof_ptr_q;
    if (flush) begin
      // An overflowed frame survives the first flush.
      if (!stat_q.ovf)
        stat_d.frame_act = 1'b0;
      stat_d.ovf    = 1'b0;
      stat_d.done   = 1'b0;
      stat_d.passed = 1'b0;
    end else begin
      if (sof && !stat_q.ovf) begin
        stat_d.frame_act = 1'b1;
        stat_d.passed    = 1'b0;
        sof_ptr_d        = wptr;
      end
      if (pass_ok)
        stat_d.passed = 1'b1;
      if (fail_ok) begin
        stat_d.frame_act = 1'b0;
        stat_d.passed    = 1'b0;
      end
      if (ovf_set)
        stat_d.ovf = 1'b1;
      if (wr_acc && eof) begin
        stat_d.frame_act = 1'b0;
        stat_d.done      = 1'b1;
      end else if (rd_ok) begin
        stat_d.done = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q    <= '0;
      sof_ptr_q <= '0;
    end else begin
      stat_q    <= stat_d;
      sof_ptr_q <= sof_ptr_d;
    end
  end

endmodule

// File: rtl/rxf_flags.sv
// Host-facing flag encoding.
module rxf_flags
  import rxf_pkg::*;
#(
  parameter int DEPTH  = 128,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1
) (
  input  rxf_stat_t        stat,
  input  logic             addr_en,
  input  logic [CNT_W-1:0] count,
  input  logic [PTR_W-1:0] thr,
  output logic             not_empty,
  output logic             ready
);

  logic gated, over;

  assign gated     = stat.frame_act && addr_en && !stat.passed;
  assign over      = count > {1'b0, thr};
  assign ready     = stat.ovf || stat.done || (over && !gated);
  assign not_empty = (count != '0) && !stat.ovf;

endmodule

// File: rtl/rx_pkt_fifo.sv
module rx_pkt_fifo
  import rxf_pkg::*;
#(
  parameter int DEPTH  = 128,
  parameter int DATA_W = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sof,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              eof,
  input  logic              addr_en,
  input  logic              addr_pass,
  input  logic              addr_fail,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  input  logic              flush,
  input  logic [PTR_W-1:0]  thr,
  output logic              frame_act,
  output logic              not_empty,
  output logic              ready
);

  logic             rst_meta_n, rst_sync_n;
  logic             wr_acc, rollback, full, rd_ok;
  logic [CNT_W-1:0] roll_ptr, wptr, count;
  rxf_stat_t        stat;

  // Reset: asserted asynchronously, released on the clock.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  rxf_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .flush    (flush),
    .wr_acc   (wr_acc),
    .wr_data  (wr_data),
    .rd_en    (rd_en),
    .rollback (rollback),
    .roll_ptr (roll_ptr),
    .wptr     (wptr),
    .count    (count),
    .full     (full),
    .rd_ok    (rd_ok),
    .rd_data  (rd_data)
  );

  rxf_frame_ctl #(.DEPTH(DEPTH)) u_ctl (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .flush     (flush),
    .sof       (sof),
    .eof       (eof),
    .wr_en     (wr_en),
    .addr_en   (addr_en),
    .addr_pass (addr_pass),
    .addr_fail (addr_fail),
    .full      (full),
    .rd_ok     (rd_ok),
    .wptr      (wptr),
    .wr_acc    (wr_acc),
    .rollback  (rollback),
    .roll_ptr  (roll_ptr),
    .stat      (stat)
  );

  rxf_flags #(.DEPTH(DEPTH)) u_flags (
    .stat      (stat),
    .addr_en   (addr_en),
    .count     (count),
    .thr       (thr),
    .not_empty (not_empty),
    .ready     (ready)
  );

  assign frame_act = stat.frame_act;

endmodule

// File: rtl/rx_pkt_fifo_chk.sv
module rx_pkt_fifo_chk
  import rxf_pkg::*;
#(
  parameter int DEPTH  = 128,
  localparam int CNT_W = $clog2(DEPTH) + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             flush,
  input logic             eof,
  input logic             addr_en,
  input logic             addr_fail,
  input logic             wr_acc,
  input logic             rd_ok,
  input logic             rollback,
  input rxf_stat_t        stat,
  input logic [CNT_W-1:0] count,
  input logic             not_empty,
  input logic             ready,
  input logic             frame_act
);

  localparam logic [CNT_W-1:0] CAP = CNT_W'(DEPTH);

  AST_CAPACITY: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CAP); // R1
  AST_EMPTY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0) |-> !not_empty); // R2
  AST_GATED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (stat.frame_act && addr_en && !stat.passed && !stat.ovf && !stat.done) |-> !ready); // R4
  AST_EOF_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_acc && eof && !flush) |=> ready); // R5
  AST_EOF_ENDS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_acc && eof && !flush) |=> !frame_act); // R6
  AST_FAIL_ENDS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_act && addr_en && addr_fail && !flush) |=> !frame_act); // R7
  AST_OVF_ENCODING: assert property (@(posedge clk) disable iff (!rst_n)
    stat.ovf |-> (ready && !not_empty)); // R8
  AST_OVF_NO_GROWTH: assert property (@(posedge clk) disable iff (!rst_n)
    (stat.ovf && !flush) |=> (count <= $past(count))); // R9
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (count == '0)); // R10
  AST_RW_BALANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_acc && rd_ok && !rollback && !flush) |=> (count == $past(count))); // R11
  AST_EMPTY_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    ((count == '0) && !wr_acc) |=> (count == '0)); // R11

endmodule

bind rx_pkt_fifo rx_pkt_fifo_chk #(.DEPTH(DEPTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .flush     (flush),
  .eof       (eof),
  .addr_en   (addr_en),
  .addr_fail (addr_fail),
  .wr_acc    (wr_acc),
  .rd_ok     (rd_ok),
  .rollback  (rollback),
  .stat      (stat),
  .count     (count),
  .not_empty (not_empty),
  .ready     (ready),
  .frame_act (frame_act)
);

// File: tb/tb_rx_pkt_fifo.sv
module tb_rx_pkt_fifo;

  localparam int DEPTH = 128;

  logic       clk;
  logic       rst_n;
  logic       sof, wr_en, eof, addr_en, addr_pass, addr_fail, rd_en, flush;
  logic [7:0] wr_data, rd_data;
  logic [6:0] thr;
  logic       frame_act, not_empty, ready;

  rx_pkt_fifo #(.DEPTH(DEPTH), .DATA_W(8)) dut (
    .clk(clk), .rst_n(rst_n), .sof(sof), .wr_en(wr_en), .wr_data(wr_data),
    .eof(eof), .addr_en(addr_en), .addr_pass(addr_pass), .addr_fail(addr_fail),
    .rd_en(rd_en), .rd_data(rd_data), .flush(flush), .thr(thr),
    .frame_act(frame_act), .not_empty(not_empty), .ready(ready)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  // Reference model
  logic [7:0] q[$];
  bit m_fa, m_pass, m_done, m_ovf;
  int m_fb;
  int tests, fails;
  bit finished;

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  task automatic check(string tag, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model_step();
    bit full_now, rdok, afail, apass, wtry;
    if (flush) begin
      if (m_ovf) m_ovf = 0; else m_fa = 0;
      q.delete(); m_done = 0; m_pass = 0; m_fb = 0;
      return;
    end
    full_now = (q.size() == DEPTH);
    rdok  = rd_en && q.size() > 0;
    afail = m_fa && addr_en && addr_fail;
    apass = m_fa && addr_en && addr_pass;
    wtry  = wr_en && m_fa && !m_ovf && !afail;
    if (sof && !m_ovf) begin m_fa = 1; m_pass = 0; m_fb = 0; end
    if (apass) m_pass = 1;
    if (afail) begin
      repeat (m_fb) void'(q.pop_back());
      m_fa = 0; m_pass = 0; m_fb = 0;
    end
    if (rdok) void'(q.pop_front());
    if (wtry && !full_now) begin q.push_back(wr_data); m_fb++; end
    if (wtry && full_now) m_ovf = 1;
    if (wtry && !full_now && eof) begin m_fa = 0; m_done = 1; end
    else if (rdok) m_done = 0;
  endtask

  task automatic compare();
    bit exp_rdy;
    exp_rdy = m_ovf || m_done ||
              (q.size() > int'(thr) && !(m_fa && addr_en && !m_pass));
    check("R2 not_empty", not_empty, (q.size() != 0 && !m_ovf));
    check("R3 ready", ready, exp_rdy);
    check("R6 frame_act", frame_act, m_fa);
    if (q.size() > 0) check("R12 rd_data", rd_data, q[0]);
  endtask

  task automatic cycle();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare();
    sof = 0; wr_en = 0; eof = 0; addr_pass = 0; addr_fail = 0; rd_en = 0; flush = 0;
  endtask

  task automatic start();        sof = 1; cycle(); endtask
  task automatic put(int b, bit last);
    wr_en = 1; wr_data = 8'(b); eof = last; cycle();
  endtask
  task automatic get();          rd_en = 1; cycle(); endtask
  task automatic do_flush();     flush = 1; cycle(); endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    tests = 0; fails = 0; finished = 0;
    m_fa = 0; m_pass = 0; m_done = 0; m_ovf = 0; m_fb = 0;
    sof = 0; wr_en = 0; eof = 0; addr_en = 0; addr_pass = 0; addr_fail = 0;
    rd_en = 0; flush = 0; wr_data = 0; thr = 7'd10;
    rst_n = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    check("R2 reset not_empty", not_empty, 0);
    check("R3 reset ready", ready, 0);
    check("R6 reset frame_act", frame_act, 0);

    // Plain frame, recognition disabled
    start();
    check("R6 frame_act after sof", frame_act, 1);
    put(8, 0);
    check("R2 not_empty after length byte", not_empty, 1);
    for (int i = 1; i < 8; i++) put(8'h30 + i, i == 7);
    check("R6 frame_act after eof", frame_act, 0);
    check("R5 ready on eof below threshold", ready, 1);
    get();
    check("R5 ready drops after one read", ready, 0);
    thr = 7'd3;
    cycle();
    check("R3 ready above threshold", ready, 1);
    repeat (7) get();
    check("R2 empty after draining", not_empty, 0);

    // Recognition gating
    thr = 7'd1; addr_en = 1;
    start();
    for (int i = 0; i < 4; i++) put(8'h40 + i, 0);
    check("R4 ready gated before pass", ready, 0);
    addr_pass = 1; cycle();
    check("R4 ready after pass", ready, 1);
    put(8'h44, 0); put(8'h45, 1);
    repeat (6) get();

    // Recognition failure with an earlier frame stored
    start(); addr_pass = 1; cycle();
    put(3, 0); put(8'hA1, 0); put(8'hA2, 1);
    start();
    for (int i = 0; i < 5; i++) put(8'hB0 + i, 0);
    addr_fail = 1; cycle();
    check("R7 frame_act drops on fail", frame_act, 0);
    check("R7 older frame intact", rd_data, 3);
    get(); get();
    check("R7 older frame last byte", rd_data, 8'hA2);
    get();
    check("R7 failed frame discarded", not_empty, 0);

    // Simultaneous read/write and empty read
    addr_en = 0; thr = 7'd10;
    start(); put(8'h11, 0);
    wr_en = 1; wr_data = 8'h22; rd_en = 1; cycle();
    check("R11 rd+wr keeps one byte", not_empty, 1);
    get();
    check("R11 count was unchanged", not_empty, 0);
    get();
    check("R11 empty read ignored", not_empty, 0);
    put(8'h5A, 1);
    check("R11 data after empty read", rd_data, 8'h5A);
    get();

    // Flush without overflow mid-frame
    start(); put(4, 0); put(5, 0);
    do_flush();
    check("R10 flush empties", not_empty, 0);
    check("R10 flush ends frame", frame_act, 0);

    // Fill to capacity, then overflow
    thr = 7'd127;
    start();
    for (int i = 0; i < 60; i++) put(i, i == 59);
    start();
    for (int i = 0; i < 68; i++) put(100 + i, 0);
    check("R1 full without overflow", not_empty, 1);
    put(8'hEE, 0);
    check("R8 not_empty low on overflow", not_empty, 0);
    check("R8 ready high on overflow", ready, 1);
    check("R8 stored data readable", rd_data, 0);
    for (int i = 0; i < 5; i++) get();
    check("R8 read order kept", rd_data, 5);
    start(); put(8'hCC, 0);
    check("R9 writes ignored in overflow", not_empty, 0);
    do_flush();
    check("R9 first flush keeps frame_act", frame_act, 1);
    check("R9 first flush clears data", not_empty, 0);
    do_flush();
    check("R9 second flush clears frame_act", frame_act, 0);
    start(); put(2, 0);
    check("R9 reception re-enabled", not_empty, 1);
    put(9, 1); get(); get();

    // Random traffic
    for (int f = 0; f < 80; f++) begin
      int len;
      bit aen, bad;
      aen = ($urandom % 2) == 1;
      bad = aen && ($urandom % 4 == 0);
      len = 2 + ($urandom % 50);
      addr_en = aen;
      thr = 7'($urandom % 128);
      start();
      for (int i = 0; i < len; i++) begin
        wr_en = 1; wr_data = 8'($urandom); eof = (i == len - 1);
        rd_en = (q.size() > m_fb) && ($urandom % 3 == 0);
        if (aen && i == len / 2) begin
          if (bad) addr_fail = 1; else addr_pass = 1;
        end
        cycle();
        if (bad && i == len / 2) break;
      end
      if (m_ovf) begin do_flush(); do_flush(); end
      repeat ($urandom % 20) begin
        rd_en = ($urandom % 2) == 1; cycle();
      end
    end
    while (q.size() > 0) get();
    check("R12 drained at end", not_empty, 0);
    summary();
  end

endmodule